// File: doc/BRIEF.md
# Cartridge Bank Controller with Latched Clock

The block decodes CPU writes into the cartridge ROM address space and keeps the banking state for a cartridge with a real-time clock. One write region turns the external RAM on and off, and another sets a 7-bit ROM bank. A third routes the external RAM window either to one of four RAM banks or to one of five clock registers. A fourth region drives a two-step latch handshake.

A free-running time counter keeps seconds, minutes, hours and a 9-bit day count, and it advances on a one-cycle tick. Software cannot read the counter while it moves. A write of 0 followed by a write of 1 to the latch region copies the counter into five stable clock registers, and software reads those registers through the window. The block drives the selected window target, the active clock register index, that register's latched value and a read byte that the bus side can return directly.

Top module: `rtc_bank_ctrl`

## Requirements
- R1: A write to region 0 (address bits [15:13] = 0) with data 0x0A sets the RAM enable, and data 0x00 clears it. Any other data leaves it unchanged.
- R2: A write to region 1 loads data bits [6:0] as the ROM bank and ignores data bit 7. A value of 0 in bits [6:0] loads bank 1.
- R3: A write to region 2 with data 0 to 3 sets the RAM bank to that value and turns clock access off.
- R4: A write to region 2 with data 0x08 to 0x0C sets the clock index to data minus 8 and turns clock access on. Any other data in region 2 changes nothing.
- R5: In region 3, data 0x01 written while unlatched copies the live counter and sets the latched flag. Data 0x00 written while latched clears the flag. Every other write leaves the flag and the clock registers unchanged, so they stay frozen while the counter runs.
- R6: The clock registers are laid out as follows. Index 0 holds seconds, 1 minutes, 2 hours and 3 day bits [7:0]. In index 4, bit 0 holds day bit 8, bits [3:1] are cleared by a latch, and bits [7:4] keep their previous value (0 after reset).
- R7: The live counter counts seconds modulo SECS_PER_MIN, minutes modulo MINS_PER_HOUR and hours modulo HOURS_PER_DAY, with carries between them. Its 9-bit day count wraps from 511 to 0. The counter advances once per cycle in which the tick is high.
- R8: The read output returns the latched register at the current index when RAM is enabled and clock access is on. Otherwise it returns 0xFF.
- R9: After reset, RAM is disabled, the ROM bank is 1, the RAM bank is 0, clock access is off, the index is 0, the latched flag is clear, and the counter and the clock registers are zero.
- R10: Writes to regions 4 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU write strobe, one cycle per write |
| wr_region_i | input | 3 | CPU address bits [15:13] of the write |
| wr_data_i | input | 8 | CPU write data |
| sec_tick_i | input | 1 | One-second tick, one cycle wide |
| ram_en_o | output | 1 | External RAM enabled |
| rom_bank_o | output | 7 | Selected ROM bank, never 0 |
| ram_bank_o | output | 2 | Selected RAM bank |
| clk_acc_o | output | 1 | Window routed to clock registers |
| clk_idx_o | output | 3 | Active clock register index |
| latched_o | output | 1 | Latched flag |
| clk_val_o | output | 8 | Latched value at the active index |
| rd_data_o | output | 8 | Window read byte |

## Verification
Each control region is driven with every one of the 256 data bytes. The bench compares each result with a model that updates only on the codes named in the requirements, so a decode that takes too wide or too narrow a range shows up. The latch is exercised with ordered sequences: 1 while already latched, 2, 0 then 1, and ticks that arrive while latched. These separate a correct handshake from one that re-samples on every 1 or that tracks the counter. Latch snapshots are taken at about twenty uneven tick counts on a small time configuration. The snapshots cover every carry chain, the crossing of day 255 into day 256 that sets the ninth bit, and the wrap from day 511 to 0, and each one is checked against values computed from the tick count.

// File: rtl/rtc_bank_pkg.sv
package rtc_bank_pkg;
  localparam int DAY_W         = 9;
  localparam int NUM_CLK_REGS  = 5;
  localparam int CLK_IDX_W     = 3;
  localparam logic [7:0] CLK_BASE = 8'h08;

  localparam logic [2:0] RGN_RAM_EN = 3'd0;
  localparam logic [2:0] RGN_ROM    = 3'd1;
  localparam logic [2:0] RGN_SEL    = 3'd2;
  localparam logic [2:0] RGN_LATCH  = 3'd3;

  localparam logic [7:0] CODE_RAM_ON  = 8'h0A;
  localparam logic [7:0] CODE_RAM_OFF = 8'h00;
  localparam logic [7:0] CODE_LATCH   = 8'h01;
  localparam logic [7:0] CODE_ARM     = 8'h00;

  typedef struct packed {
    logic [DAY_W-1:0] day;
    logic [7:0]       hr;
    logic [7:0]       mn;
    logic [7:0]       sec;
  } rtc_time_t;
endpackage

// File: rtl/rtc_wr_decode.sv
module rtc_wr_decode
  import rtc_bank_pkg::*;
#(
  parameter int ROM_W      = 7,
  parameter int RAM_BANK_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [2:0]            wr_region_i,
  input  logic [7:0]            wr_data_i,
  output logic                  ram_en_o,
  output logic [ROM_W-1:0]      rom_bank_o,
  output logic [RAM_BANK_W-1:0] ram_bank_o,
  output logic                  clk_acc_o,
  output logic [CLK_IDX_W-1:0]  clk_idx_o,
  output logic                  latched_o,
  output logic                  capture_o
);
  localparam logic [7:0] RAM_BANKS_B = 8'(2 ** RAM_BANK_W);
  localparam logic [7:0] CLK_END_B   = CLK_BASE + 8'(NUM_CLK_REGS);

  logic                  ram_en_q, clk_acc_q, latched_q;
  logic [ROM_W-1:0]      rom_q;
  logic [RAM_BANK_W-1:0] ram_bank_q;
  logic [CLK_IDX_W-1:0]  idx_q;
  logic [7:0]            clk_off;

  assign clk_off   = wr_data_i - CLK_BASE;
  assign capture_o = wr_en_i && (wr_region_i == RGN_LATCH) &&
                     (wr_data_i == CODE_LATCH) && !latched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_en_q   <= 1'b0;
      rom_q      <= ROM_W'(1);
      ram_bank_q <= '0;
      clk_acc_q  <= 1'b0;
      idx_q      <= '0;
      latched_q  <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_region_i)
        RGN_RAM_EN: begin
          if (wr_data_i == CODE_RAM_ON)       ram_en_q <= 1'b1;
          else if (wr_data_i == CODE_RAM_OFF) ram_en_q <= 1'b0;
        end
        RGN_ROM: begin
          // bank 0 is not reachable through the switchable window
          if (wr_data_i[ROM_W-1:0] == '0) rom_q <= ROM_W'(1);
          else                            rom_q <= wr_data_i[ROM_W-1:0];
        end
        RGN_SEL: begin
          if (wr_data_i < RAM_BANKS_B) begin
            ram_bank_q <= wr_data_i[RAM_BANK_W-1:0];
            clk_acc_q  <= 1'b0;
          end else if (wr_data_i >= CLK_BASE && wr_data_i < CLK_END_B) begin
            idx_q     <= clk_off[CLK_IDX_W-1:0];
            clk_acc_q <= 1'b1;
          end
        end
        RGN_LATCH: begin
          if (latched_q && wr_data_i == CODE_ARM)         latched_q <= 1'b0;
          else if (!latched_q && wr_data_i == CODE_LATCH) latched_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign ram_en_o   = ram_en_q;
  assign rom_bank_o = rom_q;
  assign ram_bank_o = ram_bank_q;
  assign clk_acc_o  = clk_acc_q;
  assign clk_idx_o  = idx_q;
  assign latched_o  = latched_q;

  AST_ROM_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_q != '0); // R2
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < CLK_IDX_W'(NUM_CLK_REGS)); // R4
  AST_RAM_EN_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ram_en_q) |-> $past(wr_en_i && wr_region_i == RGN_RAM_EN)); // R1
  AST_LATCH_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latched_q) |-> $past(wr_en_i && wr_region_i == RGN_LATCH && wr_data_i == CODE_LATCH)); // R5
  AST_HIGH_RGN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_region_i[2]) |=> $stable({ram_en_q, rom_q, ram_bank_q, clk_acc_q, idx_q, latched_q})); // R10
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_bank_pkg::*;
#(
  parameter int SECS_PER_MIN  = 60,
  parameter int MINS_PER_HOUR = 60,
  parameter int HOURS_PER_DAY = 24
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  output rtc_time_t time_o
);
  localparam logic [7:0] SEC_LAST = 8'(SECS_PER_MIN - 1);
  localparam logic [7:0] MIN_LAST = 8'(MINS_PER_HOUR - 1);
  localparam logic [7:0] HR_LAST  = 8'(HOURS_PER_DAY - 1);

  rtc_time_t t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= '0;
    end else if (tick_i) begin
      if (t_q.sec != SEC_LAST) begin
        t_q.sec <= t_q.sec + 8'd1;
      end else begin
        t_q.sec <= '0;
        if (t_q.mn != MIN_LAST) begin
          t_q.mn <= t_q.mn + 8'd1;
        end else begin
          t_q.mn <= '0;
          if (t_q.hr != HR_LAST) begin
            t_q.hr <= t_q.hr + 8'd1;
          end else begin
            t_q.hr  <= '0;
            t_q.day <= t_q.day + DAY_W'(1); // wraps naturally at 2**DAY_W
          end
        end
      end
    end
  end

  assign time_o = t_q;

  AST_SEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_q.sec <= SEC_LAST && t_q.mn <= MIN_LAST && t_q.hr <= HR_LAST); // R7
  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && t_q.sec == SEC_LAST) |=> t_q.sec == '0); // R7
  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(t_q)); // R7
endmodule

// File: rtl/rtc_latch_regs.sv
module rtc_latch_regs
  import rtc_bank_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 capture_i,
  input  rtc_time_t            time_i,
  input  logic [CLK_IDX_W-1:0] idx_i,
  output logic [7:0]           val_o
);
  logic [NUM_CLK_REGS-1:0][7:0] lat_q;
  logic [NUM_CLK_REGS-1:0][7:0] snap;

  assign snap[0] = time_i.sec;
  assign snap[1] = time_i.mn;
  assign snap[2] = time_i.hr;
  assign snap[3] = time_i.day[7:0];
  // upper nibble is preserved across a latch, day bit 8 lands in bit 0
  assign snap[4] = {lat_q[4][7:4], 3'b000, time_i.day[DAY_W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lat_q <= '0;
    else if (capture_i) lat_q <= snap;
  end

  assign val_o = (idx_i < CLK_IDX_W'(NUM_CLK_REGS)) ? lat_q[idx_i] : 8'hFF;

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(lat_q)); // R5
  AST_UPPER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> lat_q[4][7:1] == {$past(lat_q[4][7:4]), 3'b000}); // R6
endmodule

// File: rtl/rtc_bank_ctrl.sv
module rtc_bank_ctrl
  import rtc_bank_pkg::*;
#(
  parameter int SECS_PER_MIN  = 60,
  parameter int MINS_PER_HOUR = 60,
  parameter int HOURS_PER_DAY = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_region_i,
  input  logic [7:0] wr_data_i,
  input  logic       sec_tick_i,
  output logic       ram_en_o,
  output logic [6:0] rom_bank_o,
  output logic [1:0] ram_bank_o,
  output logic       clk_acc_o,
  output logic [2:0] clk_idx_o,
  output logic       latched_o,
  output logic [7:0] clk_val_o,
  output logic [7:0] rd_data_o
);
  rtc_time_t live_time;
  logic      capture;

  rtc_wr_decode #(.ROM_W(7), .RAM_BANK_W(2)) u_dec (
    .clk_i, .rst_ni, .wr_en_i, .wr_region_i, .wr_data_i,
    .ram_en_o, .rom_bank_o, .ram_bank_o, .clk_acc_o, .clk_idx_o,
    .latched_o, .capture_o(capture)
  );

  rtc_time_counter #(
    .SECS_PER_MIN(SECS_PER_MIN), .MINS_PER_HOUR(MINS_PER_HOUR),
    .HOURS_PER_DAY(HOURS_PER_DAY)
  ) u_cnt (
    .clk_i, .rst_ni, .tick_i(sec_tick_i), .time_o(live_time)
  );

  rtc_latch_regs u_lat (
    .clk_i, .rst_ni, .capture_i(capture), .time_i(live_time),
    .idx_i(clk_idx_o), .val_o(clk_val_o)
  );

  assign rd_data_o = (ram_en_o && clk_acc_o) ? clk_val_o : 8'hFF;
endmodule

// File: tb/rtc_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module rtc_bank_ctrl_tb_top;
  localparam int S = 4, M = 3, H = 2;
  localparam int PER_DAY = S * M * H;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, sec_tick_i = 1'b0;
  logic [2:0] wr_region_i = '0;
  logic [7:0] wr_data_i = '0;
  logic ram_en_o, clk_acc_o, latched_o;
  logic [6:0] rom_bank_o;
  logic [1:0] ram_bank_o;
  logic [2:0] clk_idx_o;
  logic [7:0] clk_val_o, rd_data_o;

  int checks = 0, errors = 0, n = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_bank_ctrl #(.SECS_PER_MIN(S), .MINS_PER_HOUR(M), .HOURS_PER_DAY(H)) dut_i (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_region_i, .wr_data_i, .sec_tick_i,
    .ram_en_o, .rom_bank_o, .ram_bank_o, .clk_acc_o, .clk_idx_o,
    .latched_o, .clk_val_o, .rd_data_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] r, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_region_i = r; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int k);
    @(negedge clk);
    sec_tick_i = 1'b1;
    repeat (k) @(negedge clk);
    sec_tick_i = 1'b0;
    n += k;
  endtask

  function automatic int exp_reg(input int cnt, input int k);
    int d = (cnt / PER_DAY) % 512;
    case (k)
      0: return cnt % S;
      1: return (cnt / S) % M;
      2: return (cnt / (S * M)) % H;
      3: return d % 256;
      default: return d / 256;
    endcase
  endfunction

  task automatic read_all(input int cnt, input string req);
    for (int k = 0; k < 5; k++) begin
      wr(3'd2, 8'(8 + k));
      chk(req, rd_data_o, exp_reg(cnt, k));
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    logic e_en, e_acc;
    logic [1:0] e_bank;
    logic [2:0] e_idx;
    int snap;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 ram_en", ram_en_o, 0);
    chk("R9 rom", rom_bank_o, 1);
    chk("R9 ram_bank", ram_bank_o, 0);
    chk("R9 acc", clk_acc_o, 0);
    chk("R9 idx", clk_idx_o, 0);
    chk("R9 latched", latched_o, 0);
    chk("R9 clk_val", clk_val_o, 0);
    chk("R8 rd disabled", rd_data_o, 8'hFF);

    // R1 sweep of region 0
    e_en = 0;
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, 8'(v));
      if (v == 8'h0A) e_en = 1; else if (v == 0) e_en = 0;
      chk("R1 ram_en", ram_en_o, e_en);
    end

    // R2 sweep of region 1
    for (int v = 0; v < 256; v++) begin
      wr(3'd1, 8'(v));
      chk("R2 rom", rom_bank_o, ((v % 128) == 0) ? 1 : v % 128);
    end

    // R3/R4 sweep of region 2
    e_acc = 0; e_bank = 0; e_idx = 0;
    for (int v = 0; v < 256; v++) begin
      wr(3'd2, 8'(v));
      if (v < 4) begin e_bank = 2'(v); e_acc = 0; end
      else if (v >= 8 && v <= 12) begin e_idx = 3'(v - 8); e_acc = 1; end
      chk("R3 ram_bank", ram_bank_o, e_bank);
      chk("R4 acc", clk_acc_o, e_acc);
      chk("R4 idx", clk_idx_o, e_idx);
    end

    // R10 high regions ignored, latch code included
    ticks(5);
    snap = {ram_en_o, rom_bank_o, ram_bank_o, clk_acc_o, clk_idx_o, latched_o};
    for (int r = 4; r < 8; r++) begin
      wr(3'(r), 8'h01); wr(3'(r), 8'h00); wr(3'(r), 8'h0A); wr(3'(r), 8'h09);
      chk("R10 state", {ram_en_o, rom_bank_o, ram_bank_o, clk_acc_o, clk_idx_o, latched_o}, snap);
      chk("R10 clk_val", clk_val_o, 0);
    end

    // R5/R6 latch handshake
    wr(3'd0, 8'h0A);
    wr(3'd3, 8'h00);
    chk("R5 arm no latch", latched_o, 0);
    wr(3'd3, 8'h01);
    chk("R5 latched", latched_o, 1);
    snap = n;
    read_all(snap, "R6 first latch");
    ticks(7);
    read_all(snap, "R5 frozen after ticks");
    wr(3'd3, 8'h01);
    read_all(snap, "R5 relatch ignored");
    wr(3'd3, 8'h02);
    chk("R5 code2 ignored", latched_o, 1);
    wr(3'd3, 8'h00);
    chk("R5 unlatched", latched_o, 0);
    read_all(snap, "R5 clear keeps regs");
    wr(3'd3, 8'h01);
    read_all(n, "R5 new snapshot");

    // R7/R6 long run crossing day 256 and day wrap
    for (int i = 0; i < 20; i++) begin
      ticks(650 + 7 * i);
      wr(3'd3, 8'h00);
      wr(3'd3, 8'h01);
      read_all(n, "R7 counter");
    end

    // R8 read gating
    wr(3'd2, 8'h0A);
    chk("R8 rd clock", rd_data_o, exp_reg(n, 2));
    wr(3'd0, 8'h00);
    chk("R8 rd ram off", rd_data_o, 8'hFF);
    chk("R8 clk_val kept", clk_val_o, exp_reg(n, 2));
    wr(3'd0, 8'h0A);
    wr(3'd2, 8'h01);
    chk("R8 rd ram bank", rd_data_o, 8'hFF);

    done = 1;
    finish_sim();
  end
endmodule